// File: doc/BRIEF.md
# Host Special Cycle Handler

This block sits on the processor side of a host bridge. It watches a two-phase request bus for special-cycle transactions. It reads the cycle type from the byte-enable field and then handles the cycle in one of two ways. Cache-maintenance and no-op cycles are claimed and retired at once. Shutdown and halt cycles are passed to a PCI-side master as special-cycle messages. Those cycles retire on the processor bus only after the PCI side reports that its cycle has ended.

The block handles one special cycle at a time. While a cycle is in progress it raises `busy`, and any further request is not looked at. A byte-enable code that names no known type is still claimed and retired. It causes no side effect, but it sets a sticky status flag. How the PCI bus itself signals is outside this block. It only raises a request with a message code and waits for a completion or a master-abort indication.

Top module: `host_special_cycle`

## Requirements
- R1: With `req_valid` high and `busy` low, a request whose first-phase code is 5'b01000 and whose second-phase low three bits are 3'b001 is accepted. `claim` is high for exactly the next cycle. The upper two bits of the second-phase code may take any value.
- R2: If a request does not match both codes, or if `req_valid` is low, it is not accepted. `claim`, `busy`, `retire` and `pci_sc_req` all stay low.
- R3: The type is decoded from `byte_en`: 8'h00 no-op, 8'h01 shutdown, 8'h02 flush, 8'h03 halt, 8'h04 sync.
- R4: For no-op, flush and sync, `retire` is high in the same cycle as `claim`, and `pci_sc_req` never rises.
- R5: For shutdown and halt, `pci_sc_req` rises in the cycle after acceptance. While it is high, `pci_sc_msg` holds 16'h0000 for shutdown and 16'h0001 for halt. At all other times `pci_sc_msg` is zero.
- R6: `pci_sc_req` stays high until `pci_done` or `pci_mabort` is sampled high. These inputs are ignored in the first cycle of the request. In the cycle after the indication, `pci_sc_req` is low and `retire` is high.
- R7: `retire` is a single-cycle pulse.
- R8: `busy` is high from the cycle of `claim` through the cycle of `retire`. A matching request seen while `busy` is high is ignored.
- R9: Any `byte_en` value from 8'h05 to 8'hFF is claimed and retired as in R4. `unknown_type` then becomes high in the claim cycle and stays high until reset.
- R10: While `rst` is high, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe for the two-phase request |
| req_a | input | 5 | First-phase request code |
| req_b | input | 5 | Second-phase request code |
| byte_en | input | 8 | Byte-enable field carrying the cycle type |
| pci_done | input | 1 | PCI side reports normal completion |
| pci_mabort | input | 1 | PCI side reports termination by master abort |
| claim | output | 1 | One-cycle pulse: the special cycle is claimed |
| busy | output | 1 | A special cycle is in progress |
| pci_sc_req | output | 1 | Request to the PCI master for a special cycle |
| pci_sc_msg | output | 16 | Special-cycle message code for the PCI side |
| retire | output | 1 | One-cycle pulse: retire the cycle on the processor bus |
| unknown_type | output | 1 | Sticky flag: an unlisted type was seen |

## Verification
The hardest condition to reach is a matching request arriving while a forwarded cycle is still waiting for the PCI side. The same is true for a PCI indication that arrives in the first request cycle, where it must have no effect. To reach both, the stimulus holds `req_valid` high for several cycles after a shutdown or halt is accepted. It also fires `pci_done` or `pci_mabort` at chosen delays of zero to several cycles after the request. The behavioural model in the bench tracks every one of these cycles and checks that only the first request is claimed. It also checks that retirement follows the second or later indication.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    parameter int SC_REQ_W = 5;
    parameter int SC_BE_W  = 8;

    parameter logic [SC_REQ_W-1:0] SC_A_CODE = 5'b01000;
    parameter logic [SC_REQ_W-1:0] SC_B_CODE = 5'b00001;
    parameter logic [SC_REQ_W-1:0] SC_B_MASK = 5'b00111;

    typedef enum logic [2:0] {
        SC_NOP      = 3'd0,
        SC_SHUTDOWN = 3'd1,
        SC_FLUSH    = 3'd2,
        SC_HALT     = 3'd3,
        SC_SYNC     = 3'd4,
        SC_UNKNOWN  = 3'd5
    } sc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FORWARD  = 2'd1,
        ST_WAIT_PCI = 2'd2,
        ST_RETIRE   = 2'd3
    } sc_state_e;

    typedef struct packed {
        logic     hit;
        sc_kind_e kind;
    } sc_decode_t;

    function automatic sc_kind_e sc_classify(input logic [SC_BE_W-1:0] be);
        sc_kind_e k;
        case (be)
            8'h00:   k = SC_NOP;
            8'h01:   k = SC_SHUTDOWN;
            8'h02:   k = SC_FLUSH;
            8'h03:   k = SC_HALT;
            8'h04:   k = SC_SYNC;
            default: k = SC_UNKNOWN;
        endcase
        return k;
    endfunction

    function automatic logic sc_goes_to_pci(input sc_kind_e k);
        return (k == SC_SHUTDOWN) || (k == SC_HALT);
    endfunction

endpackage

// File: rtl/hsc_decode.sv
module hsc_decode
    import hsc_pkg::*;
(
    input  logic                req_valid,
    input  logic [SC_REQ_W-1:0] req_a,
    input  logic [SC_REQ_W-1:0] req_b,
    input  logic [SC_BE_W-1:0]  byte_en,
    output sc_decode_t          dec
);
    logic a_match;
    logic b_match;

    // First-phase address content is never examined; only the codes matter.
    assign a_match  = (req_a == SC_A_CODE);
    assign b_match  = ((req_b & SC_B_MASK) == SC_B_CODE);
    assign dec.hit  = req_valid && a_match && b_match;
    assign dec.kind = sc_classify(byte_en);
endmodule

// File: rtl/hsc_seq.sv
module hsc_seq
    import hsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sc_decode_t dec,
    input  logic       pci_done,
    input  logic       pci_mabort,
    output logic       accept,
    output logic       claim,
    output logic       busy,
    output logic       fwd_active,
    output logic       retire
);
    sc_state_e state_q, state_d;
    logic      claim_q;
    logic      pci_end;

    assign pci_end = pci_done || pci_mabort;
    assign accept  = (state_q == ST_IDLE) && dec.hit;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = sc_goes_to_pci(dec.kind) ? ST_FORWARD : ST_RETIRE;
                end
            end
            ST_FORWARD:  state_d = ST_WAIT_PCI;
            ST_WAIT_PCI: if (pci_end) state_d = ST_RETIRE;
            ST_RETIRE:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            claim_q <= 1'b0;
        end else begin
            state_q <= state_d;
            claim_q <= accept;
        end
    end

    assign claim      = claim_q;
    assign busy       = (state_q != ST_IDLE);
    assign fwd_active = (state_q == ST_FORWARD) || (state_q == ST_WAIT_PCI);
    assign retire     = (state_q == ST_RETIRE);
endmodule

// File: rtl/hsc_record.sv
module hsc_record
    import hsc_pkg::*;
#(
    parameter int               MSG_W        = 16,
    parameter logic [MSG_W-1:0] SHUTDOWN_MSG = '0,
    parameter logic [MSG_W-1:0] HALT_MSG     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  sc_kind_e         kind,
    input  logic             fwd_active,
    output logic [MSG_W-1:0] pci_sc_msg,
    output logic             unknown_type
);
    logic [MSG_W-1:0] msg_q;
    logic             unk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
            unk_q <= 1'b0;
        end else if (accept) begin
            msg_q <= (kind == SC_HALT) ? HALT_MSG : SHUTDOWN_MSG;
            if (kind == SC_UNKNOWN) unk_q <= 1'b1;
        end
    end

    assign pci_sc_msg   = fwd_active ? msg_q : '0;
    assign unknown_type = unk_q;
endmodule

// File: rtl/host_special_cycle.sv
module host_special_cycle
    import hsc_pkg::*;
#(
    parameter int               MSG_W        = 16,
    parameter logic [MSG_W-1:0] SHUTDOWN_MSG = 16'h0000,
    parameter logic [MSG_W-1:0] HALT_MSG     = 16'h0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [SC_REQ_W-1:0] req_a,
    input  logic [SC_REQ_W-1:0] req_b,
    input  logic [SC_BE_W-1:0]  byte_en,
    input  logic                pci_done,
    input  logic                pci_mabort,
    output logic                claim,
    output logic                busy,
    output logic                pci_sc_req,
    output logic [MSG_W-1:0]    pci_sc_msg,
    output logic                retire,
    output logic                unknown_type
);
    sc_decode_t dec;
    logic       accept;
    logic       fwd_active;

    hsc_decode u_decode (
        .req_valid (req_valid),
        .req_a     (req_a),
        .req_b     (req_b),
        .byte_en   (byte_en),
        .dec       (dec)
    );

    hsc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .pci_done   (pci_done),
        .pci_mabort (pci_mabort),
        .accept     (accept),
        .claim      (claim),
        .busy       (busy),
        .fwd_active (fwd_active),
        .retire     (retire)
    );

    hsc_record #(
        .MSG_W        (MSG_W),
        .SHUTDOWN_MSG (SHUTDOWN_MSG),
        .HALT_MSG     (HALT_MSG)
    ) u_record (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .kind         (dec.kind),
        .fwd_active   (fwd_active),
        .pci_sc_msg   (pci_sc_msg),
        .unknown_type (unknown_type)
    );

    assign pci_sc_req = fwd_active;
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
    parameter int MSG_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             claim,
    input logic             busy,
    input logic             pci_sc_req,
    input logic [MSG_W-1:0] pci_sc_msg,
    input logic             pci_done,
    input logic             pci_mabort,
    input logic             retire,
    input logic             unknown_type
);
    AST_RETIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (pci_sc_req && !(pci_done || pci_mabort)) |=> pci_sc_req); // R6

    AST_REQ_END_RETIRES: assert property (@(posedge clk) disable iff (rst)
        $fell(pci_sc_req) |-> retire); // R6

    AST_NO_REQ_WITH_RETIRE: assert property (@(posedge clk) disable iff (rst)
        !(pci_sc_req && retire)); // R4

    AST_MSG_STEADY: assert property (@(posedge clk) disable iff (rst)
        (pci_sc_req && $past(pci_sc_req)) |-> $stable(pci_sc_msg)); // R5

    AST_CLAIM_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        claim |-> (busy && !$past(busy))); // R8

    AST_UNKNOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
        unknown_type |=> unknown_type); // R9
endmodule

bind host_special_cycle hsc_checker #(.MSG_W(MSG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .claim        (claim),
    .busy         (busy),
    .pci_sc_req   (pci_sc_req),
    .pci_sc_msg   (pci_sc_msg),
    .pci_done     (pci_done),
    .pci_mabort   (pci_mabort),
    .retire       (retire),
    .unknown_type (unknown_type)
);

// File: tb/host_special_cycle_test.sv
module host_special_cycle_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_a = '0;
    logic [4:0]  req_b = '0;
    logic [7:0]  byte_en = '0;
    logic        pci_done = 1'b0;
    logic        pci_mabort = 1'b0;
    logic        claim, busy, pci_sc_req, retire, unknown_type;
    logic [15:0] pci_sc_msg;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    host_special_cycle uut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_a        (req_a),
        .req_b        (req_b),
        .byte_en      (byte_en),
        .pci_done     (pci_done),
        .pci_mabort   (pci_mabort),
        .claim        (claim),
        .busy         (busy),
        .pci_sc_req   (pci_sc_req),
        .pci_sc_msg   (pci_sc_msg),
        .retire       (retire),
        .unknown_type (unknown_type)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Behavioural reference: phase counts where a cycle is in its life.
    int phase = 0;          // 0 free, 1 retiring, 2 first PCI cycle, 3 waiting PCI
    int e_claim = 0, e_busy = 0, e_req = 0, e_msg = 0, e_retire = 0, e_unk = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            phase = 0; e_claim = 0; e_busy = 0; e_req = 0; e_msg = 0; e_retire = 0; e_unk = 0;
        end else begin
            e_claim = 0;
            e_retire = 0;
            if (phase == 0) begin
                if (req_valid && req_a == 5'b01000 && req_b[2:0] == 3'b001) begin
                    e_claim = 1;
                    e_busy = 1;
                    if (byte_en == 8'h01 || byte_en == 8'h03) begin
                        phase = 2;
                        e_req = 1;
                        e_msg = (byte_en == 8'h03) ? 1 : 0;
                    end else begin
                        phase = 1;
                        e_retire = 1;
                        if (byte_en > 8'h04) e_unk = 1;
                    end
                end
            end else if (phase == 1) begin
                phase = 0;
                e_busy = 0;
            end else if (phase == 2) begin
                phase = 3;
            end else begin
                if (pci_done || pci_mabort) begin
                    phase = 1;
                    e_req = 0;
                    e_msg = 0;
                    e_retire = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && cycles > 0 && !finished) begin
            check("R1 R2", "claim", claim, e_claim);
            check("R4 R6 R7", "retire", retire, e_retire);
            check("R8", "busy", busy, e_busy);
            check("R5 R6", "pci_sc_req", pci_sc_req, e_req);
            check("R3 R5", "pci_sc_msg", pci_sc_msg, e_msg);
            check("R9", "unknown_type", unknown_type, e_unk);
        end
    end

    task automatic issue(input logic [4:0] a, input logic [4:0] b, input logic [7:0] be, input int hold);
        @(negedge clk);
        req_valid = 1'b1; req_a = a; req_b = b; byte_en = be;
        repeat (hold) @(negedge clk);
        req_valid = 1'b0; req_a = 5'h1f; req_b = 5'h1f; byte_en = 8'hAA;
    endtask

    task automatic pci_finish(input int delay, input bit abort);
        repeat (delay) @(negedge clk);
        if (abort) pci_mabort = 1'b1; else pci_done = 1'b1;
        @(negedge clk);
        pci_mabort = 1'b0; pci_done = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 50000 && !finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs low during reset
        check("R10", "claim in reset", claim, 0);
        check("R10", "busy in reset", busy, 0);
        check("R10", "pci_sc_req in reset", pci_sc_req, 0);
        check("R10", "retire in reset", retire, 0);
        check("R10", "unknown_type in reset", unknown_type, 0);
        check("R10", "pci_sc_msg in reset", pci_sc_msg, 0);
        rst = 1'b0;
        settle();

        // R1 R3 R4: no-op, flush, sync with varied upper second-phase bits
        issue(5'b01000, 5'b00001, 8'h00, 1); settle();
        issue(5'b01000, 5'b11001, 8'h02, 1); settle();
        issue(5'b01000, 5'b10001, 8'h04, 1); settle();

        // R2: near misses and no strobe
        issue(5'b01001, 5'b00001, 8'h02, 1); settle();
        issue(5'b01000, 5'b00011, 8'h02, 1); settle();
        @(negedge clk); req_a = 5'b01000; req_b = 5'b00001; byte_en = 8'h02;
        repeat (2) @(negedge clk);
        check("R2", "busy without strobe", busy, 0);
        settle();

        // R5 R6: shutdown ended by master abort after a wait
        issue(5'b01000, 5'b00001, 8'h01, 1);
        pci_finish(4, 1'b1); settle();

        // R6: indication during first request cycle is ignored, later done ends it
        issue(5'b01000, 5'b01001, 8'h03, 1);
        pci_finish(0, 1'b0);
        pci_finish(2, 1'b0); settle();

        // R8: request held high while a halt waits on PCI
        issue(5'b01000, 5'b00001, 8'h03, 4);
        check("R8", "busy during held request", busy, 1);
        pci_finish(1, 1'b1); settle();

        // R8: back-to-back immediates with strobe held, one accept per free slot
        issue(5'b01000, 5'b00001, 8'h02, 5); settle();

        // R9: unlisted types
        check("R9", "flag clear before unknown", unknown_type, 0);
        issue(5'b01000, 5'b00001, 8'h07, 1); settle();
        check("R9", "flag set after 0x07", unknown_type, 1);
        issue(5'b01000, 5'b00001, 8'h04, 1); settle();
        check("R9", "flag stays after sync", unknown_type, 1);
        issue(5'b01000, 5'b00001, 8'hFF, 1); settle();

        // R10: reset clears the sticky flag
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", "unknown_type after reset", unknown_type, 0);
        rst = 1'b0;
        settle();
        summary();
    end
endmodule